// File: doc/BRIEF.md
# Multi-Issue Instruction Fetch Buffer

This block sits between an instruction cache and an issue stage that takes up to four instructions per cycle, and holds up to eight fixed-length instructions. It smooths the flow of instructions between the two. The cache delivers at most one aligned line of four instructions per cycle. A line fetched for a jump target can begin part-way through, so only the slots from the start offset onward enter the buffer. A short block therefore leaves the buffer filling over several lines.

On every cycle the issue stage sees the oldest buffered instructions, up to four, in program order, each with a valid bit. It returns the number it took, and that many leave the head in the same cycle. The buffer raises a fetch stall whenever its free space is smaller than one line, and ignores lines offered during a stall. A branch misprediction flush empties it at once.

Top module: `fetch_buf`

## Requirements
- R1: After reset the buffer is empty: all four issue valid bits are 0 and the fetch stall is low.
- R2: An accepted line with start offset o (0 to 3) appends slots o, o+1, ... 3 of the line in that order. Slot j occupies bits [32*j+31:32*j] of the line bus. Slots below o are discarded.
- R3: Issue slot k (bits [32*k+31:32*k]) shows the k-th oldest buffered instruction. Its valid bit k is set exactly when more than k instructions are buffered.
- R4: A take count n removes min(n, 4, occupancy) instructions from the head at the next clock edge. Counts of 5 to 7 and counts larger than the occupancy are clamped.
- R5: The fetch stall is high when fewer than 4 entries are free. A line offered while the stall is high is not written.
- R6: A flush empties the buffer at the next edge. A line or take count presented in the same cycle has no effect.
- R7: When a line is accepted and instructions are taken in the same cycle, the occupancy becomes old + written − taken, and the order is preserved.
- R8: Storage is circular. Program order is kept across any number of pointer wrap-arounds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| flush_i | input | 1 | Misprediction flush; empties the buffer |
| fill_valid_i | input | 1 | A cache line is offered this cycle |
| fill_line_i | input | 128 | Four 32-bit instruction slots, slot 0 in the low bits |
| fill_off_i | input | 2 | Index of the first useful slot in the line |
| take_i | input | 3 | Number of instructions the issue stage took this cycle |
| issue_insn_o | output | 128 | Four oldest instructions, oldest in the low bits |
| issue_valid_o | output | 4 | Per-slot valid, thermometer coded from bit 0 |
| stall_o | output | 1 | Fetch stall: less than one line of free space |

## Verification
The bench aims at the stall boundary, with occupancy exactly 4 and 5 while lines keep being offered. A design that compares against the wrong threshold would either overwrite live entries or starve the issue stage. Offsets of 2 and 3 are checked: a design that wrote the full line or shifted the slots would show wrong or extra instructions at issue. Take counts above the issue width or the occupancy are used, and an unclamped design would drive the occupancy below zero and wrap it. Flush is applied together with a fill and a take, where a design that let the fill through would leave stale instructions behind. A long random phase wraps the pointers many times and compares the order on every cycle.

// File: rtl/fetch_buf_pkg.sv
package fetch_buf_pkg;
  localparam int unsigned INSN_W_DEF     = 32;
  localparam int unsigned LINE_SLOTS_DEF = 4;
  localparam int unsigned DEPTH_DEF      = 8;
  localparam int unsigned ISSUE_W_DEF    = 4;
endpackage

// File: rtl/fetch_buf_ctrl.sv
module fetch_buf_ctrl #(
  parameter int unsigned DEPTH      = 8,
  parameter int unsigned LINE_SLOTS = 4,
  parameter int unsigned ISSUE_W    = 4,
  localparam int unsigned PTR_W  = $clog2(DEPTH),
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1),
  localparam int unsigned OFS_W  = $clog2(LINE_SLOTS),
  localparam int unsigned TAKE_W = $clog2(ISSUE_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic             fill_valid_i,
  input  logic [OFS_W-1:0] fill_off_i,
  input  logic [TAKE_W-1:0] take_i,
  output logic [PTR_W-1:0] head_o,
  output logic [PTR_W-1:0] tail_o,
  output logic [CNT_W-1:0] occ_o,
  output logic             stall_o,
  output logic             wr_en_o
);
  logic [PTR_W-1:0] head_q, head_d, tail_q, tail_d;
  logic [CNT_W-1:0] occ_q, occ_d, wr_cnt, rd_cnt, rd_lim;

  assign stall_o = occ_q > CNT_W'(DEPTH - LINE_SLOTS);
  assign wr_en_o = fill_valid_i && !stall_o && !flush_i;

  always_comb begin
    wr_cnt = wr_en_o ? (CNT_W'(LINE_SLOTS) - CNT_W'(fill_off_i)) : '0;
    rd_lim = (occ_q < CNT_W'(ISSUE_W)) ? occ_q : CNT_W'(ISSUE_W);
    rd_cnt = (CNT_W'(take_i) > rd_lim) ? rd_lim : CNT_W'(take_i);
    if (flush_i) begin
      head_d = '0;
      tail_d = '0;
      occ_d  = '0;
    end else begin
      head_d = head_q + PTR_W'(rd_cnt);
      tail_d = tail_q + PTR_W'(wr_cnt);
      occ_d  = occ_q + wr_cnt - rd_cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      occ_q  <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      occ_q  <= occ_d;
    end
  end

  assign head_o = head_q;
  assign tail_o = tail_q;
  assign occ_o  = occ_q;
endmodule

// File: rtl/fetch_buf_store.sv
module fetch_buf_store #(
  parameter int unsigned INSN_W     = 32,
  parameter int unsigned DEPTH      = 8,
  parameter int unsigned LINE_SLOTS = 4,
  parameter int unsigned ISSUE_W    = 4,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned OFS_W = $clog2(LINE_SLOTS)
) (
  input  logic                         clk,
  input  logic                         wr_en_i,
  input  logic [OFS_W-1:0]             off_i,
  input  logic [LINE_SLOTS*INSN_W-1:0] line_i,
  input  logic [PTR_W-1:0]             tail_i,
  input  logic [PTR_W-1:0]             head_i,
  input  logic [CNT_W-1:0]             occ_i,
  output logic [ISSUE_W*INSN_W-1:0]    insn_o,
  output logic [ISSUE_W-1:0]           valid_o
);
  logic [INSN_W-1:0] mem_q [DEPTH];
  logic [INSN_W-1:0] wd    [DEPTH];
  logic [DEPTH-1:0]  we;

  always_comb begin
    we = '0;
    for (int e = 0; e < DEPTH; e++) wd[e] = '0;
    for (int j = 0; j < LINE_SLOTS; j++) begin
      if (wr_en_i && (OFS_W'(j) >= off_i)) begin
        we[tail_i + PTR_W'(j) - PTR_W'(off_i)] = 1'b1;
        wd[tail_i + PTR_W'(j) - PTR_W'(off_i)] = line_i[j*INSN_W +: INSN_W];
      end
    end
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (we[e]) mem_q[e] <= wd[e];
    end
  end

  for (genvar k = 0; k < ISSUE_W; k++) begin : g_out
    assign insn_o[k*INSN_W +: INSN_W] = mem_q[head_i + PTR_W'(k)];
    assign valid_o[k] = occ_i > CNT_W'(k);
  end
endmodule

// File: rtl/fetch_buf.sv
module fetch_buf
  import fetch_buf_pkg::*;
#(
  parameter int unsigned INSN_W     = INSN_W_DEF,
  parameter int unsigned LINE_SLOTS = LINE_SLOTS_DEF,
  parameter int unsigned DEPTH      = DEPTH_DEF,
  parameter int unsigned ISSUE_W    = ISSUE_W_DEF,
  localparam int unsigned PTR_W  = $clog2(DEPTH),
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1),
  localparam int unsigned OFS_W  = $clog2(LINE_SLOTS),
  localparam int unsigned TAKE_W = $clog2(ISSUE_W + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush_i,
  input  logic                         fill_valid_i,
  input  logic [LINE_SLOTS*INSN_W-1:0] fill_line_i,
  input  logic [OFS_W-1:0]             fill_off_i,
  input  logic [TAKE_W-1:0]            take_i,
  output logic [ISSUE_W*INSN_W-1:0]    issue_insn_o,
  output logic [ISSUE_W-1:0]           issue_valid_o,
  output logic                         stall_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_sync_n;
  logic [PTR_W-1:0] head, tail;
  logic [CNT_W-1:0] occ;
  logic             wr_en;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  fetch_buf_ctrl #(.DEPTH(DEPTH), .LINE_SLOTS(LINE_SLOTS), .ISSUE_W(ISSUE_W)) ctrl_i (
    .clk(clk), .rst_n(rst_sync_n), .flush_i(flush_i), .fill_valid_i(fill_valid_i),
    .fill_off_i(fill_off_i), .take_i(take_i), .head_o(head), .tail_o(tail),
    .occ_o(occ), .stall_o(stall_o), .wr_en_o(wr_en)
  );

  fetch_buf_store #(.INSN_W(INSN_W), .DEPTH(DEPTH), .LINE_SLOTS(LINE_SLOTS),
                    .ISSUE_W(ISSUE_W)) store_i (
    .clk(clk), .wr_en_i(wr_en), .off_i(fill_off_i), .line_i(fill_line_i),
    .tail_i(tail), .head_i(head), .occ_i(occ),
    .insn_o(issue_insn_o), .valid_o(issue_valid_o)
  );
endmodule

// File: rtl/fetch_buf_chk.sv
module fetch_buf_chk #(
  parameter int unsigned DEPTH      = 8,
  parameter int unsigned LINE_SLOTS = 4,
  parameter int unsigned ISSUE_W    = 4,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1),
  localparam int unsigned OFS_W  = $clog2(LINE_SLOTS),
  localparam int unsigned TAKE_W = $clog2(ISSUE_W + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               flush_i,
  input logic               fill_valid_i,
  input logic [OFS_W-1:0]   fill_off_i,
  input logic [TAKE_W-1:0]  take_i,
  input logic [CNT_W-1:0]   occ,
  input logic               stall_o,
  input logic [ISSUE_W-1:0] issue_valid_o
);
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (issue_valid_o == '0)) else $error("flush"); // R6

  AST_STALL_BLOCKS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_o && !flush_i && take_i == '0) |=> (occ == $past(occ))) else $error("stall"); // R5

  AST_VALID_THERMO: assert property (@(posedge clk) disable iff (!rst_n)
    ((issue_valid_o & (issue_valid_o + 1'b1)) == '0)) else $error("thermo"); // R3

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CNT_W'(DEPTH)) else $error("overflow"); // R7

  AST_FILL_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid_i && !stall_o && !flush_i && take_i == '0) |=>
      (occ == $past(occ) + CNT_W'(LINE_SLOTS) - CNT_W'($past(fill_off_i))))
    else $error("fill"); // R2

  AST_TAKE_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
    (!fill_valid_i && !flush_i && CNT_W'(take_i) <= occ && take_i <= TAKE_W'(ISSUE_W)) |=>
      (occ == $past(occ) - CNT_W'($past(take_i)))) else $error("take"); // R4
endmodule

bind fetch_buf fetch_buf_chk #(.DEPTH(DEPTH), .LINE_SLOTS(LINE_SLOTS), .ISSUE_W(ISSUE_W)) chk_i (
  .clk(clk), .rst_n(rst_sync_n), .flush_i(flush_i), .fill_valid_i(fill_valid_i),
  .fill_off_i(fill_off_i), .take_i(take_i), .occ(occ), .stall_o(stall_o),
  .issue_valid_o(issue_valid_o)
);

// File: tb/fetch_buf_tb_top.sv
module fetch_buf_tb_top;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         flush_i, fill_valid_i;
  logic [127:0] fill_line_i;
  logic [1:0]   fill_off_i;
  logic [2:0]   take_i;
  logic [127:0] issue_insn_o;
  logic [3:0]   issue_valid_o;
  logic         stall_o;

  int tests = 0;
  int fails = 0;
  int line_id = 0;
  logic [31:0] model_q[$];

  always #4 clk = ~clk;

  fetch_buf dut_i (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .fill_valid_i(fill_valid_i),
    .fill_line_i(fill_line_i), .fill_off_i(fill_off_i), .take_i(take_i),
    .issue_insn_o(issue_insn_o), .issue_valid_o(issue_valid_o), .stall_o(stall_o)
  );

  task automatic compare(string tag);
    logic [3:0] ev;
    bit ok;
    logic es;
    ev = '0;
    ok = 1'b1;
    for (int k = 0; k < 4; k++) begin
      ev[k] = (k < model_q.size());
      if (ev[k] && issue_insn_o[k*32 +: 32] !== model_q[k]) ok = 1'b0;
    end
    tests++;
    if (!ok || issue_valid_o !== ev) begin
      fails++;
      $display("FAIL %s/R3 slots: got valid %b data %h exp valid %b size %0d",
               tag, issue_valid_o, issue_insn_o, ev, model_q.size());
    end
    es = (8 - model_q.size()) < 4;
    tests++;
    if (stall_o !== es) begin
      fails++;
      $display("FAIL %s/R5 stall: got %b exp %b", tag, stall_o, es);
    end
  endtask

  task automatic step(string tag, bit fv, int off, bit fl, int tk);
    int n;
    bit acc;
    compare(tag);
    line_id++;
    for (int j = 0; j < 4; j++) fill_line_i[j*32 +: 32] = {8'(line_id), 24'(j)};
    fill_valid_i = fv;
    fill_off_i   = 2'(off);
    flush_i      = fl;
    take_i       = 3'(tk);
    @(posedge clk);
    if (fl) model_q.delete();
    else begin
      acc = fv && ((8 - model_q.size()) >= 4);
      n = tk;
      if (n > 4) n = 4;
      if (n > model_q.size()) n = model_q.size();
      for (int i = 0; i < n; i++) void'(model_q.pop_front());
      if (acc) for (int j = off; j < 4; j++) model_q.push_back({8'(line_id), 24'(j)});
    end
    @(negedge clk);
    fill_valid_i = 1'b0;
    flush_i = 1'b0;
    take_i = '0;
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    flush_i = 1'b0;
    fill_valid_i = 1'b0;
    fill_line_i = '0;
    fill_off_i = '0;
    take_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    tests++;
    if (issue_valid_o !== 4'b0 || stall_o !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset: got valid %b stall %b exp 0000 0", issue_valid_o, stall_o);
    end
    // R2 offsets
    step("R2", 1, 0, 0, 0);
    step("R2", 1, 3, 0, 0);
    step("R2", 0, 0, 0, 0);
    step("R4", 0, 0, 0, 7);       // clamp above width
    step("R2", 1, 2, 0, 0);
    step("R7", 1, 1, 0, 4);       // fill with take
    step("R5", 1, 0, 0, 0);       // fill toward full
    step("R5", 1, 0, 0, 0);       // offered while stalled
    step("R5", 1, 0, 0, 0);
    step("R4", 0, 0, 0, 3);
    step("R5", 1, 0, 0, 0);
    step("R4", 0, 0, 0, 5);
    step("R6", 1, 0, 1, 2);       // flush beats fill and take
    step("R6", 0, 0, 0, 0);
    step("R4", 0, 0, 0, 2);       // take on empty
    step("R2", 1, 3, 0, 0);
    step("R4", 0, 0, 0, 6);       // take more than held
    for (int c = 0; c < 400; c++) begin
      step("R8", $urandom_range(0, 3) != 0, $urandom_range(0, 3),
           $urandom_range(0, 40) == 0, $urandom_range(0, 7));
    end
    compare("R8");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule